// File: doc/BRIEF.md
# Timer Register Bank with Set, Clear and Toggle Aliases

This block is the register file of a four-channel 32-bit timer. It sits on a simple synchronous bus with a byte address, a write strobe, write data and read data. It holds the timer's writable configuration and drives that configuration out to the counting logic as plain output vectors. For the read-only locations it returns the live counter and prescale-count values that the counting logic feeds back in.

Every register occupies a 16-byte slot. Address bits [3:2] pick the update rule for a write: replace the contents, OR the data in, clear the ones, or invert the ones. Software can therefore change single bits of a shared register in one bus write, without a read-modify-write. Reads return the current value at any of the four aliases. Address bits [1:0] play no part in decoding.

Top module: `tmr_alias_regbank`

## Requirements
- R1: A write with address bits [3:2] = 00 replaces the whole addressed register with the write data.
- R2: A write with address bits [3:2] = 01 sets every register bit whose write-data bit is 1 and leaves the others unchanged.
- R3: A write with address bits [3:2] = 10 clears every register bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write with address bits [3:2] = 11 inverts every register bit whose write-data bit is 1 and leaves the others unchanged.
- R5: The writable registers sit at these slot base addresses, each driving its own output: interrupt flags 0x000 (`iflag_o`), control 0x010 (`ctrl_o`), direction 0x020 (`dir_o`), prescale 0x070 (`psc_o`), match control 0x090 (`mctl_o`), match values 0x0A0/0x0B0/0x0C0/0x0D0 (`match_o` channels 0 to 3, channel n in bits [32n+31:32n]), counter mode 0x180 (`cmode_o`). A write changes only the addressed register.
- R6: A read at any of the four aliases of a slot returns that slot's current value.
- R7: Reads at 0x030/0x040/0x050/0x060 return `cnt_i` channels 0 to 3, and reads at 0x080 return `pcnt_i`. Writes to these slots, at any alias, change no register.
- R8: Reads from any other slot return zero, and writes to it change no register.
- R9: While `rst_n` is low, every writable register is zero.
- R10: Read data is combinational. A read in the same cycle as a write to that register returns the value from before the write, and the new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cnt_i | input | 128 | Live counter values, channel n in bits [32n+31:32n] |
| pcnt_i | input | 32 | Live prescale count |
| iflag_o | output | 32 | Interrupt flag register |
| ctrl_o | output | 32 | Control register |
| dir_o | output | 32 | Direction register |
| psc_o | output | 32 | Prescale register |
| mctl_o | output | 32 | Match control register |
| match_o | output | 128 | Match registers, channel n in bits [32n+31:32n] |
| cmode_o | output | 32 | Counter mode register |

## Verification
A read and a write can target the same register in one cycle, because the read path is combinational and the storage is updated only at the clock edge. The bench holds an address steady with the write strobe high. It samples the read data before the edge and expects the old value, then samples after the edge and expects the value the alias rule produces. A bound property checks on every cycle that read data during a control-register write equals the register output.

// File: rtl/tab_pkg.sv
package tab_pkg;
   // update rule chosen by address bits [3:2]
   typedef enum logic [1:0] {
      OP_WRITE = 2'b00,
      OP_SET   = 2'b01,
      OP_CLR   = 2'b10,
      OP_TOG   = 2'b11
   } alias_op_e;

   // source of the read data
   typedef enum logic [1:0] {
      RD_NONE = 2'b00,
      RD_REG  = 2'b01,
      RD_CNT  = 2'b10,
      RD_PCNT = 2'b11
   } rd_src_e;

   localparam int NCH = 4;           // timer channels
   localparam int NWR = 6 + NCH;     // writable registers
   localparam int WIW = $clog2(NWR);
   localparam int CIW = $clog2(NCH);

   // storage order of the writable registers
   localparam int W_IFLAG = 0;
   localparam int W_CTRL  = 1;
   localparam int W_DIR   = 2;
   localparam int W_PSC   = 3;
   localparam int W_MCTL  = 4;
   localparam int W_MATCH = 5;       // W_MATCH .. W_MATCH+NCH-1
   localparam int W_CMODE = W_MATCH + NCH;
endpackage

// File: rtl/tab_decode.sv
module tab_decode
   import tab_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output alias_op_e         op,
   output logic [NWR-1:0]    wsel,
   output rd_src_e           rd_src,
   output logic [WIW-1:0]    rd_widx,
   output logic [CIW-1:0]    rd_cidx
);
   localparam int SW = ADDR_W - 4;

   logic [SW-1:0] slot;
   logic          wable;

   assign slot = addr[ADDR_W-1:4];
   assign op   = alias_op_e'(addr[3:2]);

   always_comb begin
      rd_src  = RD_NONE;
      rd_widx = '0;
      rd_cidx = '0;
      wable   = 1'b0;
      if (slot == SW'(0)) begin
         rd_src = RD_REG; rd_widx = WIW'(W_IFLAG); wable = 1'b1;
      end
      if (slot == SW'(1)) begin
         rd_src = RD_REG; rd_widx = WIW'(W_CTRL); wable = 1'b1;
      end
      if (slot == SW'(2)) begin
         rd_src = RD_REG; rd_widx = WIW'(W_DIR); wable = 1'b1;
      end
      for (int c = 0; c < NCH; c++) begin
         if (slot == SW'(3 + c)) begin
            rd_src = RD_CNT; rd_cidx = CIW'(c);
         end
         if (slot == SW'(10 + c)) begin
            rd_src = RD_REG; rd_widx = WIW'(W_MATCH + c); wable = 1'b1;
         end
      end
      if (slot == SW'(7)) begin
         rd_src = RD_REG; rd_widx = WIW'(W_PSC); wable = 1'b1;
      end
      if (slot == SW'(8)) begin
         rd_src = RD_PCNT;
      end
      if (slot == SW'(9)) begin
         rd_src = RD_REG; rd_widx = WIW'(W_MCTL); wable = 1'b1;
      end
      if (slot == SW'(24)) begin
         rd_src = RD_REG; rd_widx = WIW'(W_CMODE); wable = 1'b1;
      end
   end

   // one-hot write select, empty for read-only and unmapped slots
   always_comb begin
      wsel = '0;
      if (wr && wable) wsel[rd_widx] = 1'b1;
   end
endmodule

// File: rtl/tab_alias_upd.sv
module tab_alias_upd
   import tab_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alias_op_e         op,
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] nxt
);
   always_comb begin
      unique case (op)
         OP_WRITE: nxt = wdata;
         OP_SET:   nxt = cur | wdata;
         OP_CLR:   nxt = cur & ~wdata;
         OP_TOG:   nxt = cur ^ wdata;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/tmr_alias_regbank.sv
module tmr_alias_regbank
   import tab_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NCH*DATA_W-1:0] cnt_i,
   input  logic [DATA_W-1:0]     pcnt_i,
   output logic [DATA_W-1:0]     iflag_o,
   output logic [DATA_W-1:0]     ctrl_o,
   output logic [DATA_W-1:0]     dir_o,
   output logic [DATA_W-1:0]     psc_o,
   output logic [DATA_W-1:0]     mctl_o,
   output logic [NCH*DATA_W-1:0] match_o,
   output logic [DATA_W-1:0]     cmode_o
);
   // elaboration-time parameter checks
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must reach slot 0x180");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   alias_op_e                     op;
   logic [NWR-1:0]                wsel;
   rd_src_e                       rd_src;
   logic [WIW-1:0]                rd_widx;
   logic [CIW-1:0]                rd_cidx;
   logic [NWR-1:0][DATA_W-1:0]    regs_q;
   logic [NWR-1:0][DATA_W-1:0]    regs_nxt;
   logic [NCH-1:0][DATA_W-1:0]    cnt_w;

   tab_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .op      (op),
      .wsel    (wsel),
      .rd_src  (rd_src),
      .rd_widx (rd_widx),
      .rd_cidx (rd_cidx)
   );

   for (genvar i = 0; i < NWR; i++) begin : g_reg
      tab_alias_upd #(.DATA_W(DATA_W)) u_upd (
         .op    (op),
         .cur   (regs_q[i]),
         .wdata (bus_wdata),
         .nxt   (regs_nxt[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       regs_q[i] <= '0;
         else if (wsel[i]) regs_q[i] <= regs_nxt[i];
      end
   end

   assign cnt_w = cnt_i;

   always_comb begin
      unique case (rd_src)
         RD_REG:  bus_rdata = regs_q[rd_widx];
         RD_CNT:  bus_rdata = cnt_w[rd_cidx];
         RD_PCNT: bus_rdata = pcnt_i;
         default: bus_rdata = '0;
      endcase
   end

   assign iflag_o = regs_q[W_IFLAG];
   assign ctrl_o  = regs_q[W_CTRL];
   assign dir_o   = regs_q[W_DIR];
   assign psc_o   = regs_q[W_PSC];
   assign mctl_o  = regs_q[W_MCTL];
   assign cmode_o = regs_q[W_CMODE];
   for (genvar c = 0; c < NCH; c++) begin : g_match
      assign match_o[c*DATA_W +: DATA_W] = regs_q[W_MATCH + c];
   end
endmodule

// File: rtl/tab_regbank_chk.sv
module tab_regbank_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int NREG   = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic                   bus_wr,
   input logic [DATA_W-1:0]      bus_wdata,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic [DATA_W-1:0]      ctrl_o,
   input logic [NREG*DATA_W-1:0] regs
);
   logic [ADDR_W-5:0] slot;
   logic              ctrl_wr;
   logic              ro_slot;
   logic              empty_slot;

   assign slot       = bus_addr[ADDR_W-1:4];
   assign ctrl_wr    = bus_wr && (slot == (ADDR_W-4)'(1));
   assign ro_slot    = (slot >= (ADDR_W-4)'(3) && slot <= (ADDR_W-4)'(6))
                       || slot == (ADDR_W-4)'(8);
   assign empty_slot = (slot >= (ADDR_W-4)'(14)) && slot != (ADDR_W-4)'(24);

   a_r1_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && bus_addr[3:2] == 2'b00 |=> ctrl_o == $past(bus_wdata));

   a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && bus_addr[3:2] == 2'b01 |=> ctrl_o == ($past(ctrl_o) | $past(bus_wdata)));

   a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && bus_addr[3:2] == 2'b10 |=> ctrl_o == ($past(ctrl_o) & ~$past(bus_wdata)));

   a_r4_toggle_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && bus_addr[3:2] == 2'b11 |=> ctrl_o == ($past(ctrl_o) ^ $past(bus_wdata)));

   a_r7_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && ro_slot |=> $stable(regs));

   a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      empty_slot |-> bus_rdata == '0);

   a_r8_empty_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && empty_slot |=> $stable(regs));

   a_r10_read_before_update: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |-> bus_rdata == ctrl_o);
endmodule

bind tmr_alias_regbank tab_regbank_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NREG   (tab_pkg::NWR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .ctrl_o    (ctrl_o),
   .regs      (regs_q)
);

// File: tb/sim_tmr_alias_regbank.sv
`timescale 1ns/1ps
module sim_tmr_alias_regbank;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int NR = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic [4*DW-1:0] cnt_i = '0;
   logic [DW-1:0]   pcnt_i = '0;
   logic [DW-1:0]   iflag_o, ctrl_o, dir_o, psc_o, mctl_o, cmode_o;
   logic [4*DW-1:0] match_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] mdl [NR];

   always #4 clk = ~clk;   // 125 MHz

   tmr_alias_regbank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_i(cnt_i),
      .pcnt_i(pcnt_i), .iflag_o(iflag_o), .ctrl_o(ctrl_o), .dir_o(dir_o),
      .psc_o(psc_o), .mctl_o(mctl_o), .match_o(match_o), .cmode_o(cmode_o)
   );

   function automatic logic [AW-1:0] base_of(int i);
      case (i)
         0: return 12'h000;
         1: return 12'h010;
         2: return 12'h020;
         3: return 12'h070;
         4: return 12'h090;
         5: return 12'h0A0;
         6: return 12'h0B0;
         7: return 12'h0C0;
         8: return 12'h0D0;
         default: return 12'h180;
      endcase
   endfunction

   function automatic logic [DW-1:0] port_of(int i);
      case (i)
         0: return iflag_o;
         1: return ctrl_o;
         2: return dir_o;
         3: return psc_o;
         4: return mctl_o;
         5: return match_o[31:0];
         6: return match_o[63:32];
         7: return match_o[95:64];
         8: return match_o[127:96];
         default: return cmode_o;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // apply one alias write to the bench model
   task automatic mdl_write(input int i, input int op, input logic [DW-1:0] d);
      case (op)
         0: mdl[i] = d;
         1: mdl[i] = mdl[i] | d;
         2: mdl[i] = mdl[i] & ~d;
         default: mdl[i] = mdl[i] ^ d;
      endcase
      bus_write(base_of(i) + AW'(op * 4), d);
   endtask

   task automatic check_all(input string req);
      logic [DW-1:0] v;
      for (int i = 0; i < NR; i++) begin
         bus_read(base_of(i), v);
         chk(v == mdl[i], req, v, mdl[i]);
         chk(port_of(i) == mdl[i], req, port_of(i), mdl[i]);
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < NR; i++) mdl[i] = '0;
      check_all("R9 reset");
   endtask

   task automatic t_plain();
      for (int i = 0; i < NR; i++) mdl_write(i, 0, 32'h1357_0000 + 32'(i * 32'h0101_0011));
      check_all("R1/R5 plain write");
      mdl_write(3, 0, 32'h0000_0000);
      mdl_write(7, 0, 32'hFFFF_FFFF);
      check_all("R1 overwrite");
   endtask

   task automatic t_set();
      mdl_write(1, 0, 32'h0000_00F0);
      mdl_write(1, 1, 32'h0000_0F0F);
      mdl_write(6, 1, 32'h8000_0001);
      check_all("R2 set alias");
   endtask

   task automatic t_clear();
      mdl_write(1, 2, 32'h0000_0C3C);
      mdl_write(7, 2, 32'h0F0F_0F0F);
      mdl_write(0, 2, 32'h0000_0000);
      check_all("R3 clear alias");
   endtask

   task automatic t_toggle();
      mdl_write(2, 4 - 1, 32'hAAAA_5555);
      mdl_write(2, 3, 32'h0000_FFFF);
      mdl_write(9, 3, 32'h0000_00FF);
      check_all("R4 toggle alias");
   endtask

   task automatic t_alias_read();
      logic [DW-1:0] v;
      for (int i = 0; i < NR; i++)
         for (int k = 1; k < 4; k++) begin
            bus_read(base_of(i) + AW'(k * 4), v);
            chk(v == mdl[i], "R6 alias read", v, mdl[i]);
         end
   endtask

   task automatic t_readonly();
      logic [DW-1:0] v;
      logic [AW-1:0] ro [5] = '{12'h030, 12'h040, 12'h050, 12'h060, 12'h080};
      cnt_i  = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
      pcnt_i = 32'h1234_5678;
      for (int c = 0; c < 4; c++) begin
         bus_read(ro[c] + 12'h8, v);
         chk(v == cnt_i[c*32 +: 32], "R7 counter read", v, cnt_i[c*32 +: 32]);
      end
      bus_read(12'h080, v);
      chk(v == pcnt_i, "R7 prescale count read", v, pcnt_i);
      for (int r = 0; r < 5; r++)
         for (int k = 0; k < 4; k++) bus_write(ro[r] + AW'(k * 4), 32'hFFFF_FFFF);
      bus_read(12'h040, v);
      chk(v == cnt_i[63:32], "R7 counter read after write", v, cnt_i[63:32]);
      check_all("R7 read-only write ignored");
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] v;
      logic [AW-1:0] hole [4] = '{12'h0E0, 12'h100, 12'h174, 12'h19C};
      for (int h = 0; h < 4; h++) begin
         bus_write(hole[h], 32'hFFFF_FFFF);
         bus_read(hole[h], v);
         chk(v == '0, "R8 unmapped read", v, '0);
      end
      check_all("R8 unmapped write ignored");
   endtask

   task automatic t_collide();
      logic [DW-1:0] v;
      logic [DW-1:0] old;
      old = mdl[1];
      @(negedge clk);
      bus_addr = 12'h01C; bus_wdata = 32'h0000_0101; bus_wr = 1'b1;
      #1;
      chk(bus_rdata == old, "R10 read before edge", bus_rdata, old);
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      mdl[1] = old ^ 32'h0000_0101;
      #1;
      v = bus_rdata;
      chk(v == mdl[1], "R10 read after edge", v, mdl[1]);
      check_all("R10 collision state");
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_plain();
      t_set();
      t_clear();
      t_toggle();
      t_alias_read();
      t_readonly();
      t_unmapped();
      t_collide();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule